// File: doc/BRIEF.md
# Watchdog Timer with Reset or Interrupt Steering

This block is a programmable watchdog. Software writes an 8-bit setting word that holds a timeout multiplier, a resolution code and a steering bit. While the multiplier is non-zero, a cycle counter runs toward the selected timeout. It restarts on every rising edge of the external kick input and on every write to the setting word. A multiplier of zero stops the watchdog, and it is also stopped after reset.

When the count expires, the block sets a sticky watchdog flag. The steering bit then chooses one of two outputs. With steering set to reset, the block drives a fixed-length reset pulse and clears the multiplier field, so the watchdog turns itself off. With steering set to interrupt, the interrupt output stays high until software reads the flags word. Reading the flags word returns the flag and clears it.

The register port uses plain strobes. A read or write is taken on any clock edge where its strobe is high. There is no back-pressure. Read data is registered and appears the cycle after the read strobe.

Top module: `wdt_steer`

## Requirements
- R1: After reset, wd_rst_o and wd_irq_o are low, the setting word (address 0) reads 0x00 and the flags word (address 1) reads 0x00.
- R2: The timeout is mult × 2^(2 + 2·res) clock cycles. Expiry takes effect on the edge that lies exactly that many edges after the restart edge, and not one edge earlier.
- R3: While the mult field is zero, the watchdog never expires and neither output rises.
- R4: A rising edge on wd_in restarts the count. The input passes through a two-flop synchronizer, so the restart edge is the third clock edge after wd_in rises. A falling edge on wd_in has no effect.
- R5: Any write to the setting word restarts the count, even when the written value is unchanged.
- R6: Expiry sets the watchdog flag, which reads back as bit 7 of the flags word. Bits 6:0 of the flags word always read 0.
- R7: A read of the flags word returns the flag as it stood before the read and clears it. If an expiry falls on the same edge as the read, the flag stays set.
- R8: With steer = 1, expiry raises wd_rst_o for exactly RST_LEN (default 8) cycles. On the same edge it clears the mult field, keeping steer and res, so no further expiry follows. wd_irq_o does not rise.
- R9: With steer = 0, expiry raises wd_irq_o on the expiry edge. It stays high until a flags read clears it, and wd_rst_o does not rise.
- R10: Setting word layout: bit 7 is steer, bits 6:2 are mult and bits 1:0 are res. Address 0 selects the setting word and address 1 the flags word. reg_rdata is updated on the edge that takes reg_rd and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wd_in | input | 1 | Kick input; a rising edge restarts the count |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_addr | input | 1 | 0 = setting word, 1 = flags word |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| wd_rst_o | output | 1 | Reset pulse on a reset-steered expiry |
| wd_irq_o | output | 1 | Interrupt held after an interrupt-steered expiry |

## Verification
The bench anchors every expectation to a counted clock edge, and it samples on the following falling edge.

Expiry checks use the write edge or the third edge after a kick as edge zero. The bench checks that the output is low after edge L−1 and high after edge L, where L is the computed timeout. The reset pulse is then checked for high after the edge RST_LEN−1 past expiry and low after edge RST_LEN.

Read data, and the clearing of the flag and interrupt, are checked one edge after the read strobe. The bench sweeps every multiplier at the finest resolution in both steering modes, plus the end points at the coarser resolutions.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam logic ADDR_SETTING = 1'b0;
  localparam logic ADDR_FLAGS   = 1'b1;

  typedef enum logic {
    STEER_IRQ = 1'b0,
    STEER_RST = 1'b1
  } steer_e;
endpackage

// File: rtl/wdt_edge_sync.sv
module wdt_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  logic lvl;
  logic prev;

  generate
    if (STAGES == 0) begin : g_direct
      assign lvl = din;
    end else begin : g_sync
      logic [STAGES-1:0] sh;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sh <= '0;
        end else begin
          sh[0] <= din;
          for (int i = 1; i < STAGES; i++) sh[i] <= sh[i-1];
        end
      end
      assign lvl = sh[STAGES-1];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= 1'b0;
    else        prev <= lvl;
  end

  assign rise = lvl & ~prev;
endmodule

// File: rtl/wdt_timer.sv
module wdt_timer #(
  parameter int MULT_W     = 5,
  parameter int RES_W      = 2,
  parameter int BASE_SHIFT = 2,
  parameter int RES_STEP   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic [MULT_W-1:0] mult,
  input  logic [RES_W-1:0]  res,
  output logic              expire
);
  localparam int CNT_W = MULT_W + BASE_SHIFT + RES_STEP * ((1 << RES_W) - 1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] limit;
  logic             en;
  int unsigned      sh_amt;

  always_comb begin
    sh_amt = BASE_SHIFT + RES_STEP * int'(res);
    limit  = CNT_W'(mult) << sh_amt;
  end

  assign en     = |mult;
  assign expire = en && !restart && (cnt == limit - CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        cnt <= '0;
    else if (restart || !en || expire) cnt <= '0;
    else                               cnt <= cnt + CNT_W'(1);
  end
endmodule

// File: rtl/wdt_expiry_out.sv
module wdt_expiry_out #(
  parameter int RST_LEN = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic steer,
  input  logic flags_rd,
  output logic flag,
  output logic irq,
  output logic rst_pulse
);
  localparam int RC_W = $clog2(RST_LEN + 1);

  logic [RC_W-1:0] rst_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag    <= 1'b0;
      irq     <= 1'b0;
      rst_cnt <= '0;
    end else begin
      if (expire)        flag <= 1'b1;
      else if (flags_rd) flag <= 1'b0;

      if (expire && steer == wdt_pkg::STEER_IRQ) irq <= 1'b1;
      else if (flags_rd)                         irq <= 1'b0;

      if (expire && steer == wdt_pkg::STEER_RST) rst_cnt <= RC_W'(RST_LEN);
      else if (rst_cnt != '0)                    rst_cnt <= rst_cnt - RC_W'(1);
    end
  end

  assign rst_pulse = (rst_cnt != '0);
endmodule

// File: rtl/wdt_steer.sv
module wdt_steer #(
  parameter int MULT_W      = 5,
  parameter int RES_W       = 2,
  parameter int BASE_SHIFT  = 2,
  parameter int RES_STEP    = 2,
  parameter int RST_LEN     = 8,
  parameter int SYNC_STAGES = 2,
  localparam int REG_W      = 1 + MULT_W + RES_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wd_in,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic             reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic             wd_rst_o,
  output logic             wd_irq_o
);
  import wdt_pkg::*;

  logic [REG_W-1:0]  setting;
  logic [MULT_W-1:0] mult_q;
  logic [RES_W-1:0]  res_q;
  logic              steer_q;
  logic              kick;
  logic              wr_setting;
  logic              flags_rd;
  logic              restart;
  logic              expire;
  logic              flag;

  assign steer_q    = setting[REG_W-1];
  assign mult_q     = setting[REG_W-2 -: MULT_W];
  assign res_q      = setting[RES_W-1:0];
  assign wr_setting = reg_wr && (reg_addr == ADDR_SETTING);
  assign flags_rd   = reg_rd && (reg_addr == ADDR_FLAGS);
  assign restart    = wr_setting || kick;

  wdt_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(wd_in), .rise(kick)
  );

  wdt_timer #(
    .MULT_W(MULT_W), .RES_W(RES_W), .BASE_SHIFT(BASE_SHIFT), .RES_STEP(RES_STEP)
  ) u_timer (
    .clk(clk), .rst_n(rst_n), .restart(restart),
    .mult(mult_q), .res(res_q), .expire(expire)
  );

  wdt_expiry_out #(.RST_LEN(RST_LEN)) u_out (
    .clk(clk), .rst_n(rst_n), .expire(expire), .steer(steer_q),
    .flags_rd(flags_rd), .flag(flag), .irq(wd_irq_o), .rst_pulse(wd_rst_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      setting <= '0;
    end else if (wr_setting) begin
      setting <= reg_wdata;
    end else if (expire && steer_q == STEER_RST) begin
      setting[REG_W-2 -: MULT_W] <= '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      reg_rdata <= (reg_addr == ADDR_SETTING) ? setting : {flag, {(REG_W-1){1'b0}}};
    end
  end
endmodule

// File: rtl/wdt_steer_chk.sv
module wdt_steer_chk #(
  parameter int MULT_W  = 5,
  parameter int REG_W   = 8,
  parameter int RST_LEN = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_rd,
  input logic             reg_addr,
  input logic [REG_W-1:0] reg_rdata,
  input logic             wd_rst_o,
  input logic             wd_irq_o,
  input logic             expire,
  input logic             flag,
  input logic [MULT_W-1:0] mult_q
);
  localparam int HC_W = $clog2(RST_LEN + 1) + 1;

  logic [HC_W-1:0] hi_cnt;
  logic            frd;

  assign frd = reg_rd && (reg_addr == wdt_pkg::ADDR_FLAGS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        hi_cnt <= '0;
    else if (wd_rst_o) hi_cnt <= hi_cnt + HC_W'(1);
    else               hi_cnt <= '0;
  end

  a_r8_rst_not_too_long: assert property (@(posedge clk) disable iff (!rst_n)
    wd_rst_o |-> (hi_cnt < HC_W'(RST_LEN)));
  a_r8_rst_full_length: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wd_rst_o) |-> ($past(hi_cnt) == HC_W'(RST_LEN - 1)));
  a_r8_rst_disables: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wd_rst_o) |-> (mult_q == '0));
  a_r9_irq_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_irq_o && !frd) |=> wd_irq_o);
  a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (frd && !expire) |=> !flag);
  a_r6_expire_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> flag);
  a_r3_idle_when_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (mult_q == '0) |-> !expire);
  a_r6_low_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
    frd |=> (reg_rdata[REG_W-2:0] == '0));
endmodule

bind wdt_steer wdt_steer_chk #(
  .MULT_W(MULT_W), .REG_W(REG_W), .RST_LEN(RST_LEN)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_rd(reg_rd), .reg_addr(reg_addr),
  .reg_rdata(reg_rdata), .wd_rst_o(wd_rst_o), .wd_irq_o(wd_irq_o),
  .expire(expire), .flag(flag), .mult_q(mult_q)
);

// File: tb/wdt_steer_test.sv
`timescale 1ns/1ps
module wdt_steer_test;
  localparam int RST_LEN = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wd_in = 1'b0;
  logic       reg_wr = 1'b0;
  logic       reg_rd = 1'b0;
  logic       reg_addr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       wd_rst_o;
  logic       wd_irq_o;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  wdt_steer #(.RST_LEN(RST_LEN)) uut (
    .clk(clk), .rst_n(rst_n), .wd_in(wd_in), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .wd_rst_o(wd_rst_o), .wd_irq_o(wd_irq_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr_reg(input logic a, input logic [7:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    step(1);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic a, output logic [7:0] d);
    reg_rd = 1'b1; reg_addr = a;
    step(1);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  function automatic logic [7:0] cfg(input logic s, input int m, input int r);
    return {s, 5'(m), 2'(r)};
  endfunction

  function automatic int tmo(input int m, input int r);
    return m << (2 + 2 * r);
  endfunction

  task automatic irq_case(input int m, input int r);
    logic [7:0] d;
    int L;
    L = tmo(m, r);
    wr_reg(1'b0, cfg(1'b0, m, r));
    step(L - 1);
    chk("R2 irq early", wd_irq_o, 0);
    step(1);
    chk("R9 irq at expiry", wd_irq_o, 1);
    chk("R9 no reset pulse", wd_rst_o, 0);
    rd_reg(1'b1, d);
    chk("R6 flag bit7", d, 8'h80);
    chk("R9 irq cleared by read", wd_irq_o, 0);
    rd_reg(1'b1, d);
    chk("R7 flag cleared", d, 8'h00);
  endtask

  task automatic rst_case(input int m, input int r);
    logic [7:0] d;
    int L;
    L = tmo(m, r);
    wr_reg(1'b0, cfg(1'b1, m, r));
    rd_reg(1'b0, d);
    chk("R10 setting readback", d, cfg(1'b1, m, r));
    step(L - 2);
    chk("R2 reset early", wd_rst_o, 0);
    step(1);
    chk("R8 reset at expiry", wd_rst_o, 1);
    step(RST_LEN - 1);
    chk("R8 reset still high", wd_rst_o, 1);
    chk("R8 no irq", wd_irq_o, 0);
    step(1);
    chk("R8 reset ends", wd_rst_o, 0);
    rd_reg(1'b0, d);
    chk("R8 mult cleared", d, cfg(1'b1, 0, r));
    rd_reg(1'b1, d);
    chk("R6 flag after reset expiry", d, 8'h80);
    step(2 * L);
    chk("R8 no second expiry", wd_rst_o, 0);
  endtask

  initial begin : main
    logic [7:0] d;
    step(3);
    rst_n = 1'b1;
    step(1);
    chk("R1 rst out", wd_rst_o, 0);
    chk("R1 irq out", wd_irq_o, 0);
    rd_reg(1'b0, d); chk("R1 setting", d, 0);
    rd_reg(1'b1, d); chk("R1 flags", d, 0);
    step(300);
    chk("R3 idle after reset", wd_irq_o | wd_rst_o, 0);

    for (int m = 1; m < 32; m++) irq_case(m, 0);
    for (int r = 1; r < 4; r++) begin
      irq_case(1, r);
      irq_case(31, r);
    end
    for (int m = 1; m < 32; m++) rst_case(m, 0);
    rst_case(5, 2);

    // R3: writing mult 0 mid-count stops the watchdog
    wr_reg(1'b0, cfg(1'b0, 10, 0));
    step(30);
    wr_reg(1'b0, cfg(1'b0, 0, 0));
    step(200);
    chk("R3 stopped", wd_irq_o, 0);
    rd_reg(1'b1, d); chk("R3 no flag", d, 0);

    // R4: rising kick restarts on the third edge
    wr_reg(1'b0, cfg(1'b0, 10, 0));
    step(19);
    wd_in = 1'b1;
    step(3);
    step(39);
    chk("R4 kick restart early", wd_irq_o, 0);
    step(1);
    chk("R4 kick restart expiry", wd_irq_o, 1);
    rd_reg(1'b1, d);
    // R4: falling edge ignored
    wr_reg(1'b0, cfg(1'b0, 10, 0));
    step(9);
    wd_in = 1'b0;
    step(30);
    chk("R4 fall ignored early", wd_irq_o, 0);
    step(1);
    chk("R4 fall ignored expiry", wd_irq_o, 1);
    rd_reg(1'b1, d);
    // R4: repeated kicks hold off expiry
    wr_reg(1'b0, cfg(1'b0, 10, 0));
    for (int k = 0; k < 6; k++) begin
      step(20);
      wd_in = 1'b1;
      step(3);
      wd_in = 1'b0;
      step(6);
    end
    chk("R4 kicks hold off", wd_irq_o, 0);
    wr_reg(1'b0, cfg(1'b0, 0, 0));

    // R5: rewrite of same value restarts
    wr_reg(1'b0, cfg(1'b0, 10, 0));
    step(29);
    wr_reg(1'b0, cfg(1'b0, 10, 0));
    step(39);
    chk("R5 rewrite restart early", wd_irq_o, 0);
    step(1);
    chk("R5 rewrite restart expiry", wd_irq_o, 1);
    rd_reg(1'b1, d);

    // R7: read on the expiry edge leaves the flag set
    wr_reg(1'b0, cfg(1'b0, 1, 0));
    step(3);
    rd_reg(1'b1, d);
    chk("R7 same-edge read value", d, 8'h00);
    chk("R7 same-edge irq kept", wd_irq_o, 1);
    rd_reg(1'b1, d);
    chk("R7 same-edge flag kept", d, 8'h80);
    wr_reg(1'b0, cfg(1'b0, 0, 0));
    rd_reg(1'b1, d);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule